// File: doc/BRIEF.md
# Per-Thread Minimum-Interval Deadline Timer

This block gives each hardware thread of a fine-grained multithreaded core a down-counting cycle timer. It enforces a lower bound on the execution time of a code segment. A thread issues a deadline request with its thread index and a cycle count. If that thread's timer is idle at zero, the count is loaded at once and the thread runs on. If the timer is still counting, the request is parked and the thread is stalled. The parked count is loaded on the very edge at which the old one would have reached zero, so back-to-back periods are exact to the cycle.

A timer that runs out while its thread has no request waiting marks a missed deadline. The block records this in a sticky per-thread flag, which software-side logic clears through a dedicated clear line. When the exception mode input is high, the block also emits a one-cycle exception pulse. With that input low the miss is only recorded, and the timer acts purely as a minimum-time guarantee. Only one request is accepted per clock, which matches a round-robin issue slot.

Top module: `deadline_timer_unit`

## Requirements
- R1: The block serves NUM_THR (default 6) threads, each with its own timer. A request names its thread by index on `req_thread`. It affects only that thread, and an index of NUM_THR or above affects no thread.
- R2: A request to a thread whose timer holds zero loads `req_count` on the capturing edge, and the thread is not stalled.
- R3: Every nonzero timer decrements by one each clock, whatever its thread does. A timer at zero stays at zero and never wraps.
- R4: Suppose a request is captured while the thread's timer holds a value V greater than one. Then `thread_stall` for that thread is high for exactly V-1 cycles, starting right after the capturing edge. A request captured while V is one loads the new count directly, with no stall.
- R5: A parked count is loaded on the edge where the old timer would reach zero. The next expiry of that thread therefore falls exactly `req_count` cycles after the release edge.
- R6: A timer that goes from one to zero with no request parked and none arriving on that edge sets the thread's `miss_flag` after that edge. A timer that is reloaded never sets it.
- R7: `miss_flag` bits are sticky. A high `miss_clr` bit clears its flag on the next edge. If a new miss and a clear land on the same edge, the miss wins.
- R8: `miss_exc` for a thread pulses high for exactly one cycle, the same cycle its `miss_flag` is set by a miss. It does so only if `exc_mode_en` was high on the missing edge.
- R9: A request with a zero count is a pure wait. On an idle timer it does nothing (no stall, no later miss). On a running timer it stalls the thread until expiry and leaves the timer at zero, with no miss.
- R10: A request for a thread that is already stalled is ignored. The stall length and the parked count are unchanged.
- R11: Three threads each running a 5013-cycle period, starting at cycles 0, 7 and 20 and each doing 40 cycles of work per period, are stalled for the rest of every period and never miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A deadline request is offered this cycle |
| req_thread | input | TID_W | Index of the requesting thread |
| req_count | input | CNT_W | Cycle count carried by the request |
| exc_mode_en | input | 1 | High: a miss also raises the exception pulse |
| miss_clr | input | NUM_THR | Per-thread clear of the sticky miss flag |
| thread_stall | output | NUM_THR | Per-thread stall, high while a request is parked |
| miss_flag | output | NUM_THR | Sticky per-thread missed-deadline flag |
| miss_exc | output | NUM_THR | One-cycle per-thread exception pulse |

## Verification
Expiry of a running timer and the arrival of that thread's next request can land on the same edge. One such edge must yield a direct load with no stall and no miss. The bench provokes this by sweeping the request delay up to and including the full loaded count. It judges the result by the absence of stall cycles and by the miss appearing exactly the new count later. A second collision, a fresh miss against a flag clear, is driven on the missing edge itself, and the flag is expected to stay set.

// File: rtl/dl_pkg.sv
package dl_pkg;

  // What a timer slot does on the coming edge.
  typedef enum logic [2:0] {
    ACT_IDLE,    // zero, nothing requested
    ACT_LOAD,    // zero or expiring, fresh request loads directly
    ACT_COUNT,   // running, just decrement
    ACT_PARK,    // running, request parked, thread stalls
    ACT_RELOAD,  // expiring with a parked count: swap it in
    ACT_MISS     // expiring with nothing waiting
  } slot_act_e;

  function automatic slot_act_e pick_action(input logic at_zero,
                                            input logic at_one,
                                            input logic parked,
                                            input logic hit);
    slot_act_e a;
    if (at_zero)      a = hit ? ACT_LOAD : ACT_IDLE;
    else if (at_one) begin
      if (parked)     a = ACT_RELOAD;
      else if (hit)   a = ACT_LOAD;
      else            a = ACT_MISS;
    end
    else if (hit && !parked) a = ACT_PARK;
    else              a = ACT_COUNT;
    return a;
  endfunction

endpackage

// File: rtl/dl_req_decode.sv
module dl_req_decode #(
  parameter int NUM_THR = 6,
  parameter int TID_W   = 3
) (
  input  logic               req_valid,
  input  logic [TID_W-1:0]   req_thread,
  output logic [NUM_THR-1:0] hit_vec
);

  for (genvar t = 0; t < NUM_THR; t++) begin : g_hit
    assign hit_vec[t] = req_valid && (req_thread == TID_W'(t));
  end

endmodule

// File: rtl/dl_slot.sv
module dl_slot
  import dl_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  logic [CNT_W-1:0] req_count,
  input  logic             miss_clr,
  output logic             stall,
  output logic             missed,
  output logic             miss_evt
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] park_q, park_d;
  logic             parked_q, parked_d;
  logic             missed_q;
  slot_act_e        act;

  // Saturating decrement: a zero timer stays at zero.
  function automatic logic [CNT_W-1:0] dec_sat(input logic [CNT_W-1:0] v);
    return (v == '0) ? '0 : v - CNT_W'(1);
  endfunction

  assign act = pick_action(cnt_q == '0, cnt_q == CNT_W'(1), parked_q, hit);

  always_comb begin
    cnt_d    = dec_sat(cnt_q);
    park_d   = park_q;
    parked_d = parked_q;
    case (act)
      ACT_LOAD:   cnt_d = req_count;
      ACT_PARK: begin
        parked_d = 1'b1;
        park_d   = req_count;
      end
      ACT_RELOAD: begin
        cnt_d    = park_q;
        parked_d = 1'b0;
      end
      default: ;
    endcase
  end

  assign miss_evt = (act == ACT_MISS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      park_q   <= '0;
      parked_q <= 1'b0;
      missed_q <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      park_q   <= park_d;
      parked_q <= parked_d;
      if (miss_evt)      missed_q <= 1'b1;
      else if (miss_clr) missed_q <= 1'b0;
    end
  end

  assign stall  = parked_q;
  assign missed = missed_q;

endmodule

// File: rtl/deadline_timer_unit.sv
module deadline_timer_unit #(
  parameter int NUM_THR = 6,
  parameter int CNT_W   = 32,
  localparam int TID_W  = (NUM_THR > 1) ? $clog2(NUM_THR) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [TID_W-1:0]   req_thread,
  input  logic [CNT_W-1:0]   req_count,
  input  logic               exc_mode_en,
  input  logic [NUM_THR-1:0] miss_clr,
  output logic [NUM_THR-1:0] thread_stall,
  output logic [NUM_THR-1:0] miss_flag,
  output logic [NUM_THR-1:0] miss_exc
);

  // Internal events, named for the checker.
  logic [NUM_THR-1:0] hit_vec;
  logic [NUM_THR-1:0] miss_evt_vec;
  logic [NUM_THR-1:0] exc_q;

  dl_req_decode #(.NUM_THR(NUM_THR), .TID_W(TID_W)) u_dec (
    .req_valid (req_valid),
    .req_thread(req_thread),
    .hit_vec   (hit_vec)
  );

  for (genvar t = 0; t < NUM_THR; t++) begin : g_slot
    dl_slot #(.CNT_W(CNT_W)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .hit      (hit_vec[t]),
      .req_count(req_count),
      .miss_clr (miss_clr[t]),
      .stall    (thread_stall[t]),
      .missed   (miss_flag[t]),
      .miss_evt (miss_evt_vec[t])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) exc_q <= '0;
    else        exc_q <= miss_evt_vec & {NUM_THR{exc_mode_en}};
  end

  assign miss_exc = exc_q;

endmodule

// File: rtl/dl_timer_checker.sv
module dl_timer_checker #(
  parameter int NUM_THR = 6,
  parameter int TID_W   = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic [TID_W-1:0]   req_thread,
  input logic               exc_mode_en,
  input logic [NUM_THR-1:0] miss_clr,
  input logic [NUM_THR-1:0] thread_stall,
  input logic [NUM_THR-1:0] miss_flag,
  input logic [NUM_THR-1:0] miss_exc,
  input logic [NUM_THR-1:0] hit_vec,
  input logic [NUM_THR-1:0] miss_evt_vec
);

  // R1: at most one thread is addressed per cycle
  assert_one_hit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  // R1: an out-of-range index reaches no thread
  assert_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (int'(req_thread) >= NUM_THR)) |-> (hit_vec == '0));

  for (genvar t = 0; t < NUM_THR; t++) begin : g_chk
    // R4: a stall only begins after a request for that thread
    assert_stall_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(thread_stall[t]) |-> $past(hit_vec[t]));

    // R6: a parked thread cannot miss
    assert_no_miss_parked_R6: assert property (@(posedge clk) disable iff (!rst_n)
      thread_stall[t] |-> !miss_evt_vec[t]);

    // R6: a miss event raises the flag
    assert_miss_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      miss_evt_vec[t] |=> miss_flag[t]);

    // R7: flag holds without a clear
    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (miss_flag[t] && !miss_clr[t]) |=> miss_flag[t]);

    // R7: clear wins only when no miss lands on the same edge
    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (miss_clr[t] && !miss_evt_vec[t]) |=> !miss_flag[t]);

    // R8: pulse needs a miss and the mode bit on the previous edge
    assert_exc_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      miss_exc[t] |-> ($past(exc_mode_en) && $past(miss_evt_vec[t])));

    // R8: pulse lasts one cycle
    assert_exc_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      miss_exc[t] |=> !miss_exc[t]);

    // R8: pulse appears together with the flag
    assert_exc_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      miss_exc[t] |-> miss_flag[t]);
  end

endmodule

bind deadline_timer_unit dl_timer_checker #(.NUM_THR(NUM_THR), .TID_W(TID_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_thread  (req_thread),
  .exc_mode_en (exc_mode_en),
  .miss_clr    (miss_clr),
  .thread_stall(thread_stall),
  .miss_flag   (miss_flag),
  .miss_exc    (miss_exc),
  .hit_vec     (hit_vec),
  .miss_evt_vec(miss_evt_vec)
);

// File: tb/deadline_timer_unit_bench.sv
module deadline_timer_unit_bench;

  localparam int NT   = 6;
  localparam int CW   = 32;
  localparam int PER  = 5013;
  localparam int WORK = 40;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid;
  logic [2:0]    req_thread;
  logic [CW-1:0] req_count;
  logic          exc_mode_en;
  logic [NT-1:0] miss_clr;
  logic [NT-1:0] thread_stall;
  logic [NT-1:0] miss_flag;
  logic [NT-1:0] miss_exc;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  deadline_timer_unit u_deadline_timer_unit (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_thread  (req_thread),
    .req_count   (req_count),
    .exc_mode_en (exc_mode_en),
    .miss_clr    (miss_clr),
    .thread_stall(thread_stall),
    .miss_flag   (miss_flag),
    .miss_exc    (miss_exc)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Request captured by the next rising edge; returns at the negedge after it.
  task automatic issue(input int t, input longint cnt);
    req_valid  = 1'b1;
    req_thread = 3'(t);
    req_count  = CW'(cnt);
    @(negedge clk);
    req_valid  = 1'b0;
    req_count  = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_all();
    miss_clr = '1;
    @(negedge clk);
    miss_clr = '0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    req_valid = 1'b0; req_thread = '0; req_count = '0;
    exc_mode_en = 1'b0; miss_clr = '0;
    idle(3);
    rst_n = 1'b1;
    idle(1);
  endtask

  // Load c, then after d cycles request p; measure stall length and miss time.
  task automatic pair(input int t, input int c, input int d, input int p, input bit exc);
    int  stall_n;
    int  miss_i;
    int  last;
    bit  exc_at;
    bit  exc_after;
    exc_mode_en = exc;
    clear_all();
    chk("R7 cleared before trial", miss_flag[t], 0);
    issue(t, c);
    chk("R2 idle load no stall", thread_stall[t], 0);
    idle(d - 1);
    issue(t, p);
    stall_n = 0; miss_i = -1; exc_at = 0; exc_after = 0;
    last = c - d + p + 2;
    for (int i = 0; i <= last; i++) begin
      if (thread_stall[t]) stall_n++;
      if (miss_flag[t] && miss_i < 0) begin
        miss_i = i;
        exc_at = miss_exc[t];
      end else if (miss_i >= 0 && i == miss_i + 1) begin
        exc_after = miss_exc[t];
      end
      if (i != last) @(negedge clk);
    end
    chk("R4 stall length", stall_n, c - d);
    chk("R5 R6 miss after reload", miss_i, c - d + p);
    chk("R8 exception at miss", exc_at, exc);
    chk("R8 exception one cycle", exc_after, 0);
    chk("R1 other threads untouched", (miss_flag | thread_stall) & ~(NT'(1) << t), 0);
  endtask

  initial begin
    int mism [3];
    int offs [3];
    int trial;
    offs = '{0, 7, 20};
    do_reset();
    chk("R3 reset stall", thread_stall, 0);
    chk("R6 reset flags", miss_flag, 0);
    chk("R8 reset pulses", miss_exc, 0);

    // R11 three periodic threads
    for (int i = 0; i < 3; i++) mism[i] = 0;
    for (int c = 0; c < 4 * PER + 30; c++) begin
      req_valid = 1'b0;
      for (int i = 0; i < 3; i++) begin
        if (c == offs[i] ||
            (c > offs[i] && (c - offs[i]) % PER == WORK && (c - offs[i]) / PER < 4)) begin
          req_valid  = 1'b1;
          req_thread = 3'(i);
          req_count  = CW'(PER);
        end
      end
      @(negedge clk);
      for (int i = 0; i < 3; i++) begin
        if (thread_stall[i] !== ((c >= offs[i]) && ((c - offs[i]) % PER >= WORK)))
          mism[i]++;
      end
    end
    req_valid = 1'b0;
    for (int i = 0; i < 3; i++) chk("R11 periodic stall mismatches", mism[i], 0);
    chk("R11 no misses", miss_flag, 0);

    do_reset();

    // R4 R5 R6 R8 sweep, including request on the expiry edge (d == c)
    trial = 0;
    for (int c = 2; c <= 7; c++)
      for (int d = 1; d <= c; d++)
        for (int p = 1; p <= 4; p++) begin
          pair(trial % NT, c, d, p, bit'(trial % 2));
          trial++;
        end

    // R10 request during a stall is ignored
    exc_mode_en = 1'b0;
    clear_all();
    issue(0, 6);
    issue(0, 2);
    chk("R10 stalled after park", thread_stall[0], 1);
    issue(0, 9);
    begin
      int stall_n = 1;
      int miss_i = -1;
      for (int i = 1; i <= 12; i++) begin
        if (thread_stall[0]) stall_n++;
        if (miss_flag[0] && miss_i < 0) miss_i = i;
        @(negedge clk);
      end
      chk("R10 stall length unchanged", stall_n, 5);
      chk("R10 parked count unchanged", miss_i, 7);
    end

    // R9 zero-count requests
    clear_all();
    issue(2, 0);
    chk("R9 zero on idle no stall", thread_stall[2], 0);
    idle(12);
    chk("R9 zero on idle no miss", miss_flag[2], 0);
    issue(2, 5);
    idle(1);
    issue(2, 0);
    begin
      int stall_n = 0;
      for (int i = 0; i < 12; i++) begin
        if (thread_stall[2]) stall_n++;
        @(negedge clk);
      end
      chk("R9 pure wait stall", stall_n, 3);
    end
    chk("R9 pure wait no miss", miss_flag[2], 0);
    issue(2, 3);
    chk("R9 timer left at zero", thread_stall[2], 0);
    idle(2);
    chk("R9 no early miss", miss_flag[2], 0);
    idle(1);
    chk("R9 miss after fresh load", miss_flag[2], 1);

    // R7 miss and clear on the same edge
    clear_all();
    exc_mode_en = 1'b1;
    issue(3, 3);
    idle(2);
    miss_clr[3] = 1'b1;
    @(negedge clk);
    miss_clr = '0;
    chk("R7 miss beats clear", miss_flag[3], 1);
    chk("R8 pulse with mode on", miss_exc[3], 1);
    miss_clr[3] = 1'b1;
    @(negedge clk);
    miss_clr = '0;
    chk("R7 clear alone", miss_flag[3], 0);

    // R3 timer stays at zero: no second miss
    idle(30);
    chk("R3 no wrap after expiry", miss_flag[3], 0);
    chk("R3 no further pulse", miss_exc[3], 0);

    // R1 out-of-range index
    issue(6, 4);
    issue(7, 4);
    idle(8);
    chk("R1 out-of-range no stall", thread_stall, 0);
    chk("R1 out-of-range no miss", miss_flag, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule